// File: doc/BRIEF.md
# Dual-Width Integer ALU with Byte-Order Conversion

This block is the execute stage for the integer arithmetic of a 64-bit register machine. Each request carries a 4-bit operation code, a mode bit that selects full 64-bit or 32-bit arithmetic, and a source-select bit that chooses the second operand: either the source register value or a 32-bit immediate that the block sign-extends. It also carries an extended-mode enable that turns on signed division and signed remainder. The destination register value is always the first operand. The block returns the value to write back to the destination register.

Requests use a start/done handshake. All operations except division finish one cycle after they are accepted. Unsigned and signed divide and remainder go through a radix-2 iterative divider and take a fixed number of cycles. While that work is in progress, busy is high and new requests are ignored. A byte-order conversion operation is also provided. For this one, the source-select bit gives the direction and the immediate gives the width. The host byte order is taken to be little-endian.

Top module: `alu_dualwidth`

## Requirements
- R1: While reset is high and in the first cycle after it, done and busy are 0 and result is 0.
- R2: When use_reg is 0 the second operand is imm sign-extended to 64 bits. When use_reg is 1 it is src_val.
- R3: When wide is 0, both operands are reduced to their low 32 bits and treated as unsigned, and result bits 63:32 are 0. The only exception is code 0xD (R10).
- R4: These codes finish one cycle after start is accepted, with done high for that cycle: 0x0 add, 0x1 subtract (dst minus operand), 0x2 multiply (low bits), 0x4 or, 0x5 and, 0xA xor, 0xB move (result is the second operand), 0x8 negate (two's complement of dst, operand unused).
- R5: Code 0x6 shifts left and code 0x7 shifts right logically. Code 0xC shifts right arithmetically, using the sign bit of the active width. The shift amount is the low 6 bits of the second operand in 64-bit mode and the low 5 bits in 32-bit mode.
- R6: Code 0x3 (unsigned divide) and code 0x9 (unsigned remainder) raise busy in the cycle after acceptance and keep done low until they complete. The result then arrives with done no more than 66 cycles after acceptance. Busy and done are never high together.
- R7: When ext_en is 1, code 0xE is a signed divide and code 0xF is a signed remainder, both on the active width. The quotient truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 returns the most negative value, with remainder 0.
- R8: When ext_en is 0, codes 0xE and 0xF finish in one cycle and return the destination operand reduced to the active width.
- R9: With a zero divisor, divide codes return 0 and remainder codes return the dividend reduced to the active width.
- R10: Code 0xD converts byte order, and the mode bit has no effect on it. The width is 16 bits when imm is 16, 32 bits when imm is 32, and 64 bits for any other imm. With use_reg 0 the result is the low bytes of dst_val within that width, zero-extended. With use_reg 1 the bytes within the width are reversed, then zero-extended.
- R11: A start that arrives while busy is high is ignored. It produces no extra done and does not change the pending result.
- R12: result keeps its value in every cycle where done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when busy is low |
| op | input | 4 | Operation code |
| wide | input | 1 | 1: 64-bit mode, 0: 32-bit mode |
| use_reg | input | 1 | Second operand select / byte-order direction |
| ext_en | input | 1 | Enables signed divide and remainder |
| dst_val | input | 64 | Destination register value (first operand) |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate, sign-extended for use as operand |
| busy | output | 1 | Iterative division in progress |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | 64 | Registered write-back value |

## Verification
A corrupted remainder or quotient register in the divider stays hidden until the division finishes. It then appears as a wrong result in the done cycle, about 65 cycles after start. Sign-fix or divide-by-zero flags that are latched wrongly appear in that same done cycle, and only for operand signs or zero divisors that exercise them. A wrong one-cycle path or mode mask shows up on the very next cycle. The bench therefore mixes random operands with the most negative values, all-ones values, zero divisors and every byte-order width, and it compares each done cycle against its own model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
    OP_OR   = 4'h4, OP_AND  = 4'h5, OP_LSH  = 4'h6, OP_RSH  = 4'h7,
    OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR  = 4'hA, OP_MOV  = 4'hB,
    OP_ARSH = 4'hC, OP_END  = 4'hD, OP_SDIV = 4'hE, OP_SMOD = 4'hF
  } op_e;

  typedef enum logic [1:0] {
    SW_16   = 2'd0,
    SW_32   = 2'd1,
    SW_FULL = 2'd2
  } swap_w_e;
endpackage

// File: rtl/alu_byteswap.sv
module alu_byteswap
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] x,
  input  logic            to_big,
  input  swap_w_e         wsel,
  output logic [XLEN-1:0] y
);
  localparam int NB = XLEN / 8;

  logic [XLEN-1:0] rev_full;
  logic [31:0]     rev_32;
  logic [15:0]     rev_16;

  genvar k;
  generate
    for (k = 0; k < NB; k++) begin : g_full
      assign rev_full[8*k +: 8] = x[8*(NB-1-k) +: 8];
    end
    for (k = 0; k < 4; k++) begin : g_w32
      assign rev_32[8*k +: 8] = x[8*(3-k) +: 8];
    end
    for (k = 0; k < 2; k++) begin : g_w16
      assign rev_16[8*k +: 8] = x[8*(1-k) +: 8];
    end
  endgenerate

  always_comb begin
    unique case (wsel)
      SW_16:   y = to_big ? {{(XLEN-16){1'b0}}, rev_16} : {{(XLEN-16){1'b0}}, x[15:0]};
      SW_32:   y = to_big ? {{(XLEN-32){1'b0}}, rev_32} : {{(XLEN-32){1'b0}}, x[31:0]};
      default: y = to_big ? rev_full : x;
    endcase
  end
endmodule

// File: rtl/alu_onecycle.sv
module alu_onecycle
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  op_e             opc,
  input  logic            wide,
  input  logic            use_reg,
  input  logic [XLEN/2-1:0] imm,
  input  logic [XLEN-1:0] raw_a,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int H   = XLEN / 2;
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] swapped;
  logic [XLEN-1:0] raw_res;
  logic signed [XLEN-1:0] a_s;
  logic signed [H-1:0]    a_lo_s;
  logic signed [XLEN-1:0] sra_full;
  logic signed [H-1:0]    sra_lo;
  swap_w_e wsel;

  assign shamt  = wide ? b[SHW-1:0] : {1'b0, b[SHW-2:0]};
  assign a_s    = a;
  assign a_lo_s = a[H-1:0];
  assign sra_full = a_s >>> shamt;
  assign sra_lo   = a_lo_s >>> shamt;

  assign wsel = (imm == H'(16)) ? SW_16 : (imm == H'(32)) ? SW_32 : SW_FULL;

  alu_byteswap #(.XLEN(XLEN)) u_swap (
    .x      (raw_a),
    .to_big (use_reg),
    .wsel   (wsel),
    .y      (swapped)
  );

  always_comb begin
    unique case (opc)
      OP_ADD:  raw_res = a + b;
      OP_SUB:  raw_res = a - b;
      OP_MUL:  raw_res = a * b;
      OP_OR:   raw_res = a | b;
      OP_AND:  raw_res = a & b;
      OP_XOR:  raw_res = a ^ b;
      OP_MOV:  raw_res = b;
      OP_NEG:  raw_res = -a;
      OP_LSH:  raw_res = a << shamt;
      OP_RSH:  raw_res = a >> shamt;
      OP_ARSH: raw_res = wide ? sra_full : {{H{1'b0}}, sra_lo};
      default: raw_res = a;
    endcase
  end

  assign res = (opc == OP_END) ? swapped :
               (wide ? raw_res : {{H{1'b0}}, raw_res[H-1:0]});
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            fin,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);
  localparam int CW = $clog2(XLEN);

  logic            active;
  logic [CW-1:0]   cnt;
  logic [XLEN:0]   r_q;
  logic [XLEN-1:0] q_q;
  logic [XLEN-1:0] d_q;
  logic [XLEN:0]   r_sh;
  logic            fits;

  assign r_sh = {r_q[XLEN-1:0], q_q[XLEN-1]};
  assign fits = (r_sh >= {1'b0, d_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      r_q    <= '0;
      q_q    <= '0;
      d_q    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
        r_q    <= '0;
        q_q    <= dividend;
        d_q    <= divisor;
      end else if (active) begin
        r_q <= fits ? (r_sh - {1'b0, d_q}) : r_sh;
        q_q <= {q_q[XLEN-2:0], fits};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(XLEN-1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  assign quo = q_q;
  assign rem = r_q[XLEN-1:0];
endmodule

// File: rtl/alu_dualwidth.sv
module alu_dualwidth
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic              wide,
  input  logic              use_reg,
  input  logic              ext_en,
  input  logic [XLEN-1:0]   dst_val,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN/2-1:0] imm,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   result
);
  localparam int H = XLEN / 2;

  op_e opc;
  logic [XLEN-1:0] b_sel, a_m, b_m, a_neg_m, b_neg_m, a_mag, b_mag;
  logic [XLEN-1:0] one_res, quo, rem, q_fix, r_fix, div_raw, div_res;
  logic accept, signed_op, is_mod, is_div, a_neg, b_neg, div_fin;

  logic            busy_q, done_q;
  logic [XLEN-1:0] res_q;
  logic            qneg_q, rneg_q, zero_q, mod_q, wide_q;
  logic [XLEN-1:0] a_keep_q;

  assign opc   = op_e'(op);
  assign b_sel = use_reg ? src_val : {{H{imm[H-1]}}, imm};
  assign a_m   = wide ? dst_val : {{H{1'b0}}, dst_val[H-1:0]};
  assign b_m   = wide ? b_sel   : {{H{1'b0}}, b_sel[H-1:0]};

  assign accept    = start && !busy_q;
  assign signed_op = (opc == OP_SDIV) || (opc == OP_SMOD);
  assign is_mod    = (opc == OP_MOD) || (opc == OP_SMOD);
  assign is_div    = (opc == OP_DIV) || (opc == OP_MOD) || (signed_op && ext_en);

  assign a_neg = signed_op && (wide ? a_m[XLEN-1] : a_m[H-1]);
  assign b_neg = signed_op && (wide ? b_m[XLEN-1] : b_m[H-1]);

  assign a_neg_m = wide ? (-a_m) : {{H{1'b0}}, (-a_m[H-1:0])};
  assign b_neg_m = wide ? (-b_m) : {{H{1'b0}}, (-b_m[H-1:0])};
  assign a_mag   = a_neg ? a_neg_m : a_m;
  assign b_mag   = b_neg ? b_neg_m : b_m;

  alu_onecycle #(.XLEN(XLEN)) u_one (
    .opc     (opc),
    .wide    (wide),
    .use_reg (use_reg),
    .imm     (imm),
    .raw_a   (dst_val),
    .a       (a_m),
    .b       (b_m),
    .res     (one_res)
  );

  alu_divider #(.XLEN(XLEN)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (accept && is_div),
    .dividend (a_mag),
    .divisor  (b_mag),
    .fin      (div_fin),
    .quo      (quo),
    .rem      (rem)
  );

  assign q_fix   = qneg_q ? (-quo) : quo;
  assign r_fix   = rneg_q ? (-rem) : rem;
  assign div_raw = zero_q ? (mod_q ? a_keep_q : '0) : (mod_q ? r_fix : q_fix);
  assign div_res = wide_q ? div_raw : {{H{1'b0}}, div_raw[H-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      res_q    <= '0;
      qneg_q   <= 1'b0;
      rneg_q   <= 1'b0;
      zero_q   <= 1'b0;
      mod_q    <= 1'b0;
      wide_q   <= 1'b1;
      a_keep_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (is_div) begin
          busy_q   <= 1'b1;
          qneg_q   <= a_neg ^ b_neg;
          rneg_q   <= a_neg;
          zero_q   <= (b_m == '0);
          mod_q    <= is_mod;
          wide_q   <= wide;
          a_keep_q <= a_m;
        end else begin
          res_q  <= one_res;
          done_q <= 1'b1;
        end
      end else if (busy_q && div_fin) begin
        res_q  <= div_res;
        done_q <= 1'b1;
        busy_q <= 1'b0;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/alu_checks.sv
module alu_checks #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [3:0]        op,
  input logic              wide,
  input logic              use_reg,
  input logic              ext_en,
  input logic [XLEN-1:0]   dst_val,
  input logic [XLEN-1:0]   src_val,
  input logic [XLEN/2-1:0] imm,
  input logic              busy,
  input logic              done,
  input logic [XLEN-1:0]   result
);
  localparam int H = XLEN / 2;

  logic       acc, div_req, gated;
  logic [3:0] op_q;
  logic       wide_q;
  logic [7:0] busy_cnt;

  assign acc     = start && !busy;
  assign gated   = (op == 4'hE || op == 4'hF) && !ext_en;
  assign div_req = (op == 4'h3) || (op == 4'h9) || ((op == 4'hE || op == 4'hF) && ext_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= 4'h0;
      wide_q   <= 1'b1;
      busy_cnt <= '0;
    end else begin
      if (acc) begin
        op_q   <= op;
        wide_q <= wide;
      end
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!done && !busy && result == '0));

  p_zext_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !wide_q && op_q != 4'hD) |-> (result[XLEN-1:H] == '0));

  p_single_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && !div_req) |=> (done && !busy));

  p_div_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && div_req) |=> (busy && !done));

  p_div_bound_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt <= 8'(XLEN + 2)));

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && gated) |=> (result == (wide_q ? $past(dst_val) : {{H{1'b0}}, $past(dst_val[H-1:0])})));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

bind alu_dualwidth alu_checks #(.XLEN(XLEN)) u_alu_checks (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .op      (op),
  .wide    (wide),
  .use_reg (use_reg),
  .ext_en  (ext_en),
  .dst_val (dst_val),
  .src_val (src_val),
  .imm     (imm),
  .busy    (busy),
  .done    (done),
  .result  (result)
);

// File: tb/test_alu_dualwidth.sv
module test_alu_dualwidth;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = 4'h0;
  logic        wide = 1'b1, use_reg = 1'b0, ext_en = 1'b0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [31:0] imm = '0;
  logic        busy, done;
  logic [63:0] result;

  int n_total = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  alu_dualwidth i_alu_dualwidth (
    .clk(clk), .rst(rst), .start(start), .op(op), .wide(wide),
    .use_reg(use_reg), .ext_en(ext_en), .dst_val(dst_val),
    .src_val(src_val), .imm(imm), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [3:0] o, input logic w, input logic u,
                                        input logic e, input logic [63:0] d,
                                        input logic [63:0] s, input logic [31:0] im);
    logic [63:0] a, b, r;
    int sh, nb;
    longint sa, sb;
    int sa32, sb32;
    b = u ? s : {{32{im[31]}}, im};
    a = w ? d : {32'd0, d[31:0]};
    if (!w) b = {32'd0, b[31:0]};
    sh = w ? int'(b[5:0]) : int'(b[4:0]);
    r = a;
    case (o)
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'hA: r = a ^ b;
      4'hB: r = b;
      4'h8: r = 64'd0 - a;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'hC: begin
        if (w) begin sa = longint'(a); r = 64'(sa >>> sh); end
        else begin sa32 = int'(a[31:0]); r = {32'd0, 32'(sa32 >>> sh)}; end
      end
      4'h3: r = (b == 0) ? 64'd0 : a / b;
      4'h9: r = (b == 0) ? a : a % b;
      4'hE, 4'hF: begin
        if (!e) r = a;
        else if (b == 0) r = (o == 4'hF) ? a : 64'd0;
        else if (w) begin
          sa = longint'(a); sb = longint'(b);
          if (sb == -1) r = (o == 4'hF) ? 64'd0 : 64'(-sa);
          else r = (o == 4'hF) ? 64'(sa % sb) : 64'(sa / sb);
        end else begin
          sa32 = int'(a[31:0]); sb32 = int'(b[31:0]);
          if (sb32 == -1) r = (o == 4'hF) ? 64'd0 : {32'd0, 32'(-sa32)};
          else r = (o == 4'hF) ? {32'd0, 32'(sa32 % sb32)} : {32'd0, 32'(sa32 / sb32)};
        end
      end
      4'hD: begin
        nb = (im == 32'd16) ? 2 : (im == 32'd32) ? 4 : 8;
        r = '0;
        for (int k = 0; k < nb; k++)
          r[8*k +: 8] = u ? d[8*(nb-1-k) +: 8] : d[8*k +: 8];
        return r;
      end
      default: r = a;
    endcase
    return w ? r : {32'd0, r[31:0]};
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic e);
    case (o)
      4'h6, 4'h7, 4'hC: return "R5";
      4'h3, 4'h9:       return "R6";
      4'hE, 4'hF:       return e ? "R7" : "R8";
      4'hD:             return "R10";
      default:          return "R4";
    endcase
  endfunction

  // Issue one request at a falling edge, wait for done, compare; lat >= 0 also checks latency
  task automatic run_op(input string tag, input logic [3:0] o, input logic w, input logic u,
                        input logic e, input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] im, input int lat);
    logic [63:0] exp;
    int n;
    exp = model(o, w, u, e, d, s, im);
    op = o; wide = w; use_reg = u; ext_en = e; dst_val = d; src_val = s; imm = im;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(tag, result, exp);
    if (lat >= 0) check({tag, " latency"}, 64'(n), 64'(lat));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_total++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [63:0] held;
    int dcount, seed_v;
    seed_v = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 busy", {63'd0, busy}, 64'd0);
    check("R1 result", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {62'd0, busy, done}, 64'd0);

    // R2: immediate sign-extended vs register operand
    run_op("R2 imm", 4'h0, 1, 0, 0, 64'd0, 64'h5, 32'hFFFF_FFFF, 1);
    run_op("R2 reg", 4'h0, 1, 1, 0, 64'd3, 64'h1_0000_0000, 32'h7, 1);
    // R3: 32-bit wrap and zero extension
    run_op("R3 wrap", 4'h0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'd1, 1);
    run_op("R3 mov", 4'hB, 0, 0, 0, 64'd0, 64'd0, 32'h8000_0000, 1);
    // R4: single-cycle ops
    run_op("R4 sub", 4'h1, 1, 1, 0, 64'd5, 64'd7, 32'd0, 1);
    run_op("R4 neg", 4'h8, 0, 0, 0, 64'd1, 64'd0, 32'd0, 1);
    // R5: shift masking and arithmetic shift
    run_op("R5 lsh mask32", 4'h6, 0, 0, 0, 64'd1, 64'd0, 32'd33, 1);
    run_op("R5 arsh32", 4'hC, 0, 0, 0, 64'h8000_0000, 64'd0, 32'd4, 1);
    run_op("R5 arsh64", 4'hC, 1, 0, 0, 64'h8000_0000_0000_0000, 64'd0, 32'd67, 1);
    // R6: unsigned divide
    run_op("R6 div", 4'h3, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 32'd0, -1);
    run_op("R6 mod32", 4'h9, 0, 0, 0, 64'd100, 64'd0, 32'd7, -1);
    // R7: signed divide corners
    run_op("R7 min/-1 64", 4'hE, 1, 0, 1, 64'h8000_0000_0000_0000, 64'd0, 32'hFFFF_FFFF, -1);
    run_op("R7 min/-1 32", 4'hE, 0, 0, 1, 64'h8000_0000, 64'd0, 32'hFFFF_FFFF, -1);
    run_op("R7 smod neg", 4'hF, 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFF9, 64'd0, 32'd2, -1);
    // R8: signed ops disabled
    run_op("R8 gated", 4'hE, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'd3, 1);
    // R9: zero divisor
    run_op("R9 div0", 4'h3, 1, 1, 0, 64'd77, 64'd0, 32'd0, -1);
    run_op("R9 mod0", 4'h9, 1, 1, 0, 64'd77, 64'd0, 32'd0, -1);
    run_op("R9 smod0 32", 4'hF, 0, 1, 1, 64'hAB_8000_0001, 64'h5_0000_0000, 32'd0, -1);
    // R10: byte order
    run_op("R10 le16", 4'hD, 1, 0, 0, 64'h1122_3344_5566_7788, 64'd0, 32'd16, 1);
    run_op("R10 be16", 4'hD, 0, 1, 0, 64'h1122_3344_5566_7788, 64'd0, 32'd16, 1);
    run_op("R10 be32", 4'hD, 0, 1, 0, 64'h1122_3344_5566_7788, 64'd0, 32'd32, 1);
    run_op("R10 be64", 4'hD, 0, 1, 0, 64'h1122_3344_5566_7788, 64'd0, 32'd64, 1);

    // R11: start during a division is ignored
    op = 4'h3; wide = 1; use_reg = 0; ext_en = 0; dst_val = 64'd100; imm = 32'd7;
    start = 1'b1;
    @(negedge clk);
    op = 4'h0; dst_val = 64'd5; imm = 32'd1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    dcount = 0;
    while (!done && dcount < 200) begin @(negedge clk); dcount++; end
    check("R11 result", result, 64'd14);
    held = result;
    dcount = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (done) dcount++;
    end
    check("R11 extra done", 64'(dcount), 64'd0);
    check("R12 hold", result, held);

    // Random mix, tagged by operation class
    for (int i = 0; i < 400; i++) begin
      logic [3:0] o;
      logic [63:0] d, s;
      logic [31:0] im;
      logic w, u, e;
      o = 4'($urandom % 16);
      w = 1'($urandom); u = 1'($urandom); e = 1'($urandom);
      d = {$urandom, $urandom};
      s = {$urandom, $urandom};
      im = $urandom;
      case ($urandom % 6)
        0: d = 64'h8000_0000_0000_0000;
        1: s = 64'($urandom % 5);
        2: im = 32'($urandom % 4) - 32'd2;
        default: ;
      endcase
      if (o == 4'hD) im = (i % 4 == 0) ? 32'd16 : (i % 4 == 1) ? 32'd32 : (i % 4 == 2) ? 32'd64 : im;
      run_op(tag_of(o, e), o, w, u, e, d, s, im, -1);
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule